// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

The block holds two independent sets of alarm registers and compares each set against the live BCD time and calendar fields supplied by an external clock core. The compared fields are seconds, minutes, hour, date, month and day of week. Every alarm register carries an enable bit in bit 7 and a BCD compare value in bits 6:0. Only enabled fields take part in the comparison. This lets one comparator express yearly, weekly, daily or other periodic alarms.

Comparison happens only on the cycle that the clock core marks with `tick_i`, which comes right after its counters update. Each match therefore gives exactly one `match_o` pulse. That pulse sets the alarm's flag in a separate status block. The stored flags come back on `flag_i`. Each flag can be routed to the shared active-low interrupt pin under its own interrupt-enable input. Software can instead poll the flags.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every alarm register of both alarms reads 0x00, `match_o` is 0, and `irq_no` is high while no flag is set.
- R2: A write of `wr_data_i` to field `wr_field_i` of alarm `wr_alarm_i` reads back on `rd_data_o` from the next cycle. The field codes are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month and 5 day of week. Writes to codes 6 and 7 are ignored, and reads of those codes return 0x00.
- R3: When `tick_i` is high and every enabled field of an alarm equals its live field, that alarm's `match_o` bit is high in the following cycle and only for that one cycle.
- R4: A field whose enable bit (bit 7) is 0 does not affect the match, whatever its compare value.
- R5: An alarm whose six enable bits are all 0 never matches, even when its compare values equal the time.
- R6: No `match_o` pulse occurs in a cycle that did not follow a `tick_i`.
- R7: Each alarm matches only from its own registers. A match of one alarm does not pulse the other.
- R8: The hour compare uses all seven hour bits exactly as the clock presents them, so in 12-hour mode the PM bit (bit 5) must agree. For example, 0x29 (9 PM) does not match 0x09 (9 AM).
- R9: `irq_no` is low exactly when some alarm has both its `flag_i` bit and its `irq_en_i` bit set.
- R10: A mismatch in any single enabled field prevents the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | High for one cycle after the time counters update |
| time_i | input | 42 | Live fields, 7 bits each: seconds [6:0], minutes [13:7], hour [20:14], date [27:21], month [34:28], day of week [41:35] |
| wr_en_i | input | 1 | Register write strobe |
| wr_alarm_i | input | 1 | Alarm selected for the write |
| wr_field_i | input | 3 | Field code for the write |
| wr_data_i | input | 8 | Write data: bit 7 enable, bits 6:0 compare value |
| rd_alarm_i | input | 1 | Alarm selected for the read |
| rd_field_i | input | 3 | Field code for the read |
| rd_data_o | output | 8 | Read data for the selected register (combinational) |
| irq_en_i | input | 2 | Per-alarm interrupt enable |
| flag_i | input | 2 | Per-alarm flag state from the status block |
| match_o | output | 2 | Per-alarm one-cycle match pulse |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: two alarms, six fields and a 7-bit compare value. With these values the 3-bit field code has two unused codes, so the ignored writes and zero reads of R2 can be exercised. Alarm 0 is set up as a daily 9:30 PM alarm in 12-hour encoding. Alarm 1 is set up as a weekly alarm with a disabled seconds value, which exercises R4, R7 and R8 against each other. Alarm 1 is then rewritten with every enable cleared, so the same time pattern shows the never-match rule of R5.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned ALARMS_DEF = 2;
  localparam int unsigned FIELDS_DEF = 6;
  localparam int unsigned BCD_W_DEF  = 7;

  // field codes; order matches the time_i packing
  localparam int unsigned FLD_SEC  = 0;
  localparam int unsigned FLD_MIN  = 1;
  localparam int unsigned FLD_HOUR = 2;
  localparam int unsigned FLD_DATE = 3;
  localparam int unsigned FLD_MON  = 4;
  localparam int unsigned FLD_DOW  = 5;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int unsigned NUM_FIELDS = alarm_pkg::FIELDS_DEF,
  parameter int unsigned VAL_W      = alarm_pkg::BCD_W_DEF,
  localparam int unsigned SEL_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS + 1) : 1,
  localparam int unsigned REG_W     = VAL_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            waddr_i,
  input  logic [REG_W-1:0]            wdata_i,
  input  logic [SEL_W-1:0]            raddr_i,
  output logic [REG_W-1:0]            rdata_o,
  output logic [NUM_FIELDS-1:0]       en_o,
  output logic [NUM_FIELDS*VAL_W-1:0] val_o
);
  logic [NUM_FIELDS-1:0][REG_W-1:0] regs_q;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[f] <= '0;
      else if (we_i && (waddr_i == SEL_W'(f)))     regs_q[f] <= wdata_i;
    end
    assign en_o[f]                 = regs_q[f][REG_W-1];
    assign val_o[f*VAL_W +: VAL_W] = regs_q[f][VAL_W-1:0];
  end

  // unused codes read as zero
  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < int'(NUM_FIELDS); f++)
      if (raddr_i == SEL_W'(f)) rdata_o = regs_q[f];
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int unsigned NUM_FIELDS = alarm_pkg::FIELDS_DEF,
  parameter int unsigned VAL_W      = alarm_pkg::BCD_W_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [NUM_FIELDS*VAL_W-1:0] time_i,
  input  logic [NUM_FIELDS-1:0]       en_i,
  input  logic [NUM_FIELDS*VAL_W-1:0] val_i,
  output logic                        match_o
);
  logic [NUM_FIELDS-1:0] hit;
  logic                  match_d;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_hit
    // masked field always counts as a hit
    assign hit[f] = !en_i[f] || (val_i[f*VAL_W +: VAL_W] == time_i[f*VAL_W +: VAL_W]);
  end

  // an alarm with no enables never fires
  assign match_d = tick_i && (|en_i) && (&hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_o <= 1'b0;
    else         match_o <= match_d;
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int unsigned NUM_ALARMS = alarm_pkg::ALARMS_DEF,
  parameter int unsigned NUM_FIELDS = alarm_pkg::FIELDS_DEF,
  parameter int unsigned VAL_W      = alarm_pkg::BCD_W_DEF,
  localparam int unsigned ALM_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
  localparam int unsigned SEL_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS + 1) : 1,
  localparam int unsigned REG_W     = VAL_W + 1,
  localparam int unsigned TIME_W    = NUM_FIELDS * VAL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [TIME_W-1:0]     time_i,
  input  logic                  wr_en_i,
  input  logic [ALM_W-1:0]      wr_alarm_i,
  input  logic [SEL_W-1:0]      wr_field_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic [ALM_W-1:0]      rd_alarm_i,
  input  logic [SEL_W-1:0]      rd_field_i,
  output logic [REG_W-1:0]      rd_data_o,
  input  logic [NUM_ALARMS-1:0] irq_en_i,
  input  logic [NUM_ALARMS-1:0] flag_i,
  output logic [NUM_ALARMS-1:0] match_o,
  output logic                  irq_no
);
  logic [NUM_ALARMS-1:0][REG_W-1:0]  rdata;
  logic [NUM_ALARMS*NUM_FIELDS-1:0]  en_all;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alm
    logic [NUM_FIELDS-1:0] en;
    logic [TIME_W-1:0]     val;

    alarm_regfile #(.NUM_FIELDS(NUM_FIELDS), .VAL_W(VAL_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_alarm_i == ALM_W'(a))),
      .waddr_i (wr_field_i),
      .wdata_i (wr_data_i),
      .raddr_i (rd_field_i),
      .rdata_o (rdata[a]),
      .en_o    (en),
      .val_o   (val)
    );

    alarm_cmp #(.NUM_FIELDS(NUM_FIELDS), .VAL_W(VAL_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .time_i  (time_i),
      .en_i    (en),
      .val_i   (val),
      .match_o (match_o[a])
    );

    assign en_all[a*NUM_FIELDS +: NUM_FIELDS] = en;
  end

  always_comb begin
    rd_data_o = '0;
    for (int a = 0; a < int'(NUM_ALARMS); a++)
      if (rd_alarm_i == ALM_W'(a)) rd_data_o = rdata[a];
  end

  assign irq_no = ~|(flag_i & irq_en_i);
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk #(
  parameter int unsigned NUM_ALARMS = alarm_pkg::ALARMS_DEF,
  parameter int unsigned NUM_FIELDS = alarm_pkg::FIELDS_DEF
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             tick_i,
  input logic [NUM_ALARMS-1:0]            match_o,
  input logic [NUM_ALARMS-1:0]            flag_i,
  input logic [NUM_ALARMS-1:0]            irq_en_i,
  input logic                             irq_no,
  input logic [NUM_ALARMS*NUM_FIELDS-1:0] en_i
);
  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
    // R6
    match_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[a] |-> $past(tick_i));
    // R3
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o[a] && !tick_i) |=> !match_o[a]);
    // R5
    no_enable_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && (en_i[a*NUM_FIELDS +: NUM_FIELDS] == '0)) |=> !match_o[a]);
  end

  // R9
  irq_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & irq_en_i) != '0) |-> !irq_no);
  // R9
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & irq_en_i) == '0) |-> irq_no);
endmodule

bind alarm_match_unit alarm_match_unit_chk #(
  .NUM_ALARMS(NUM_ALARMS),
  .NUM_FIELDS(NUM_FIELDS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .match_o  (match_o),
  .flag_i   (flag_i),
  .irq_en_i (irq_en_i),
  .irq_no   (irq_no),
  .en_i     (en_all)
);

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
  typedef struct packed {
    logic [41:0] tm;   // {dow, month, date, hour, min, sec}
    logic        tick;
    logic [1:0]  exp;
  } vec_t;

  // alarm0: daily 9:30 PM (12h hour 0x29); alarm1: weekly dow 3, 08:00, sec 0x45 masked
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{{7'h2, 7'h06, 7'h15, 7'h29, 7'h30, 7'h00}, 1'b1, 2'b01}, // R3 daily hit
    '{{7'h2, 7'h06, 7'h15, 7'h29, 7'h30, 7'h00}, 1'b0, 2'b00}, // R6 no tick
    '{{7'h2, 7'h06, 7'h15, 7'h29, 7'h31, 7'h00}, 1'b1, 2'b00}, // R10 minute off
    '{{7'h2, 7'h06, 7'h15, 7'h09, 7'h30, 7'h00}, 1'b1, 2'b00}, // R8 AM vs PM
    '{{7'h3, 7'h06, 7'h15, 7'h08, 7'h00, 7'h12}, 1'b1, 2'b10}, // R4 R7 weekly hit
    '{{7'h4, 7'h06, 7'h15, 7'h08, 7'h00, 7'h12}, 1'b1, 2'b00}, // R10 wrong day
    '{{7'h3, 7'h11, 7'h02, 7'h29, 7'h30, 7'h59}, 1'b1, 2'b01}, // R7 alarm0 only
    '{{7'h0, 7'h01, 7'h01, 7'h12, 7'h00, 7'h00}, 1'b1, 2'b00}  // R10 nothing
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [41:0] time_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_alarm_i = 1'b0;
  logic [2:0]  wr_field_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        rd_alarm_i = 1'b0;
  logic [2:0]  rd_field_i = '0;
  logic [7:0]  rd_data_o;
  logic [1:0]  irq_en_i = '0;
  logic [1:0]  flag_i = '0;
  logic [1:0]  match_o;
  logic        irq_no;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_match_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .time_i(time_i),
    .wr_en_i(wr_en_i), .wr_alarm_i(wr_alarm_i), .wr_field_i(wr_field_i),
    .wr_data_i(wr_data_i), .rd_alarm_i(rd_alarm_i), .rd_field_i(rd_field_i),
    .rd_data_o(rd_data_o), .irq_en_i(irq_en_i), .flag_i(flag_i),
    .match_o(match_o), .irq_no(irq_no)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [2:0] f, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_alarm_i = a; wr_field_i = f; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic a, input logic [2:0] f,
                        input logic [7:0] exp);
    rd_alarm_i = a; rd_field_i = f;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic apply(input string req, input logic [41:0] tm, input logic tk,
                       input logic [1:0] exp);
    @(negedge clk);
    time_i = tm; tick_i = tk;
    @(negedge clk);
    tick_i = 1'b0;
    check(req, {6'b0, match_o}, {6'b0, exp});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 2; a++)
      for (int f = 0; f < 6; f++)
        rd_chk("R1 reset reg", a[0], f[2:0], 8'h00);
    check("R1 reset match", {6'b0, match_o}, 8'h00);
    check("R1 reset irq", {7'b0, irq_no}, 8'h01);

    // program alarms
    wr(1'b0, 3'd1, 8'hB0);
    wr(1'b0, 3'd2, 8'hA9);
    wr(1'b1, 3'd0, 8'h45);
    wr(1'b1, 3'd1, 8'h80);
    wr(1'b1, 3'd2, 8'h88);
    wr(1'b1, 3'd5, 8'h83);

    // R2 readback and unused codes
    rd_chk("R2 readback a0 hour", 1'b0, 3'd2, 8'hA9);
    rd_chk("R2 readback a1 sec", 1'b1, 3'd0, 8'h45);
    rd_chk("R2 readback a1 dow", 1'b1, 3'd5, 8'h83);
    wr(1'b0, 3'd6, 8'hFF);
    wr(1'b1, 3'd7, 8'hFF);
    rd_chk("R2 unused code 6", 1'b0, 3'd6, 8'h00);
    rd_chk("R2 unused code 7", 1'b1, 3'd7, 8'h00);
    rd_chk("R2 neighbour intact", 1'b0, 3'd5, 8'h00);

    for (int i = 0; i < NV; i++)
      apply($sformatf("vector %0d (R3/R4/R6/R7/R8/R10)", i), VECS[i].tm, VECS[i].tick,
            VECS[i].exp);

    // R3 back-to-back ticks each give a pulse, then it drops
    apply("R3 repeat tick", VECS[0].tm, 1'b1, 2'b01);
    apply("R3 repeat tick 2", VECS[0].tm, 1'b1, 2'b01);
    @(negedge clk);
    check("R3 pulse ends", {6'b0, match_o}, 8'h00);

    // R5 alarm1 values equal but every enable cleared
    wr(1'b1, 3'd0, 8'h12);
    wr(1'b1, 3'd1, 8'h00);
    wr(1'b1, 3'd2, 8'h08);
    wr(1'b1, 3'd5, 8'h03);
    apply("R5 all disabled", VECS[4].tm, 1'b1, 2'b00);
    rd_chk("R5 reg cleared enable", 1'b1, 3'd2, 8'h08);

    // R9 interrupt gating
    flag_i = 2'b01; irq_en_i = 2'b00; #1;
    check("R9 flag no enable", {7'b0, irq_no}, 8'h01);
    irq_en_i = 2'b10; #1;
    check("R9 other enable", {7'b0, irq_no}, 8'h01);
    irq_en_i = 2'b01; #1;
    check("R9 flag0 enabled", {7'b0, irq_no}, 8'h00);
    flag_i = 2'b10; irq_en_i = 2'b11; #1;
    check("R9 flag1 enabled", {7'b0, irq_no}, 8'h00);
    flag_i = 2'b00; #1;
    check("R9 flags clear", {7'b0, irq_no}, 8'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule